// File: doc/BRIEF.md
# DDR2 Column Command Spacing Controller

This block stands between a queue of column requests and the command bus of a DDR2-style SDRAM. Each request names a bank and a direction (read or write). The block holds back a request until the target bank is open and the required spacing after earlier column commands has passed. It then issues the command with posted CAS. It also predicts the clock cycles in which read data comes back and the cycles in which write data must be driven. The predictions are given as two window strobes.

Read latency is additive latency plus CAS latency. Write latency is one clock less than read latency. Burst length is 4 or 8, so each burst takes half that many clocks on the data bus. Reads may stream with no gap on the data bus: one read every burst-length/2 clocks, to the same bank or to different banks. A write that follows a read waits two extra clocks so the bus can turn around. Bank open flags are kept from external activate and precharge strobes. The latency and burst settings are taken only while nothing is in flight.

Requests arrive on a valid/ready stream. The source holds `req_valid` high, with `req_write` and `req_bank` stable, until it sees `req_ready` high in the same cycle. `req_ready` is a function of the bank, the direction and the spacing state. It does not depend on `req_valid`, so the source may check it before it commits a request. There is no back-pressure on the command side: every accepted request appears on the command bus one clock later.

Top module: `ddr2cc_sched`

## Requirements
- R1: After reset, the following hold. `cmd_op` is NOP (0). Both window strobes are low. All 8 banks are closed, so `req_ready` is low for every bank. The configuration is AL=0, CL=3, burst length 4.
- R2: A request accepted in cycle k (`req_valid` and `req_ready` both high) puts its command on `cmd_op` in cycle k+1: READ=1 for `req_write`=0 and WRITE=2 for `req_write`=1. In the same cycle `cmd_bank` equals the accepted `req_bank`.
- R3: `bank_act` opens bank `bank_sel` from the next cycle on, and `bank_pre` closes it. If both strobes are high in the same cycle, precharge wins. `req_ready` is low whenever `req_bank` is closed, so a request to a closed bank is held.
- R4: Any two column commands are at least BL/2 clocks apart on `cmd_op`, so reads can stream every 2 clocks (BL4) or every 4 clocks (BL8). `req_ready` is high as soon as this spacing and the bank and turnaround conditions allow.
- R5: A WRITE comes at least 4 clocks (BL4) or 6 clocks (BL8) after the previous READ.
- R6: Read latency RL = AL + CL. After a READ on `cmd_op` in cycle c, `rd_win` is high in cycles c+RL through c+RL+BL/2-1.
- R7: Write latency WL = RL-1. After a WRITE in cycle c, `wr_win` is high in cycles c+WL through c+WL+BL/2-1.
- R8: `cfg_load` takes AL, CL and burst length (`cfg_bl8`=1 selects 8) on the next edge, but only when four things hold in that cycle. No request is accepted. No read was issued within the last RL+BL/2 cycles, this cycle included. No write was issued within the last WL+BL/2 cycles, this cycle included. The values are in range: AL 0..5 and CL 3..6. In every other case the load is ignored.
- R9: In a cycle that follows a cycle with no accepted request, `cmd_op` is NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_act | input | 1 | Activate strobe: opens bank `bank_sel` |
| bank_pre | input | 1 | Precharge strobe: closes bank `bank_sel` |
| bank_sel | input | 3 | Bank addressed by the activate/precharge strobes |
| cfg_load | input | 1 | Request to load latency and burst settings |
| cfg_al | input | 3 | Additive latency to load |
| cfg_cl | input | 3 | CAS latency to load |
| cfg_bl8 | input | 1 | 1 selects burst length 8, 0 selects 4 |
| req_valid | input | 1 | Column request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_bank | input | 3 | Target bank of the request |
| cmd_op | output | 2 | Column command: 0 NOP, 1 READ, 2 WRITE |
| cmd_bank | output | 3 | Bank of the command on `cmd_op` |
| rd_win | output | 1 | Read data is expected on the bus in this cycle |
| wr_win | output | 1 | Write data must be driven in this cycle |

## Verification
The bench goes after the spacing edges. It requests a read exactly BL/2 clocks after the previous read, and a write exactly at the turnaround limit. A timer that is off by one either leaves a bubble in a read stream or lets a write collide with returning read data. It tries to load the configuration while the last window is still finishing, and the window position of the next read shows whether the block used latencies that were stale or changed mid-flight. It also strikes activate and precharge at the same bank in one cycle, sends requests to closed banks, and sends loads out of range. These expose a wrong precedence, a command issued to a closed bank, or an illegal latency that was accepted.

// File: rtl/ddr2cc_pkg.sv
package ddr2cc_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_RD  = 2'd1,
    CMD_WR  = 2'd2
  } col_cmd_e;
endpackage

// File: rtl/ddr2cc_bank_flags.sv
module ddr2cc_bank_flags #(
  parameter int NB = 8,
  localparam int BW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act,
  input  logic          pre,
  input  logic [BW-1:0] sel,
  output logic [NB-1:0] open_mask
);
  for (genvar b = 0; b < NB; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          open_mask[b] <= 1'b0;
      else if (pre && sel == BW'(b))       open_mask[b] <= 1'b0;
      else if (act && sel == BW'(b))       open_mask[b] <= 1'b1;
    end
  end
endmodule

// File: rtl/ddr2cc_gap_timer.sv
module ddr2cc_gap_timer #(
  parameter int CW = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic issue,
  input  logic issue_rd,
  input  logic bl8,
  output logic col_ok,
  output logic wr_ok
);
  logic [CW-1:0] any_cnt, r2w_cnt, half;

  assign half   = bl8 ? CW'(4) : CW'(2);
  assign col_ok = (any_cnt == '0);
  assign wr_ok  = (r2w_cnt == '0);

  // Counters are loaded with gap-1 at the accepting edge; the command
  // appears one cycle later, so zero is reached exactly gap cycles on.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      any_cnt <= '0;
      r2w_cnt <= '0;
    end else begin
      if (issue)                any_cnt <= half - CW'(1);
      else if (any_cnt != '0)   any_cnt <= any_cnt - CW'(1);
      if (issue && issue_rd)    r2w_cnt <= half + CW'(1);
      else if (r2w_cnt != '0)   r2w_cnt <= r2w_cnt - CW'(1);
    end
  end
endmodule

// File: rtl/ddr2cc_data_window.sv
module ddr2cc_data_window #(
  parameter int DEPTH = 15,
  parameter int LW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] lat,
  input  logic [2:0]    beats,
  output logic          win,
  output logic          live
);
  // hist[i] set: a command of this kind was on the bus i cycles ago
  logic [DEPTH-1:0] hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist <= '0;
    else        hist <= {hist[DEPTH-2:0], start};
  end

  always_comb begin
    int first_i, end_i;
    first_i = int'(lat);
    end_i   = int'(lat) + int'(beats);
    win  = 1'b0;
    live = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (hist[i] && i >= first_i && i < end_i) win  = 1'b1;
      if (hist[i] && i < end_i)                 live = 1'b1;
    end
  end
endmodule

// File: rtl/ddr2cc_sched.sv
module ddr2cc_sched #(
  parameter int NB     = 8,
  parameter int MAX_AL = 5,
  parameter int MIN_CL = 3,
  parameter int MAX_CL = 6,
  localparam int BW    = $clog2(NB),
  localparam int AW    = $clog2(MAX_AL + 1),
  localparam int CLW   = $clog2(MAX_CL + 1),
  localparam int LW    = $clog2(MAX_AL + MAX_CL + 1),
  localparam int DEPTH = MAX_AL + MAX_CL + 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bank_act,
  input  logic           bank_pre,
  input  logic [BW-1:0]  bank_sel,
  input  logic           cfg_load,
  input  logic [AW-1:0]  cfg_al,
  input  logic [CLW-1:0] cfg_cl,
  input  logic           cfg_bl8,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_write,
  input  logic [BW-1:0]  req_bank,
  output logic [1:0]     cmd_op,
  output logic [BW-1:0]  cmd_bank,
  output logic           rd_win,
  output logic           wr_win
);
  import ddr2cc_pkg::*;

  logic [NB-1:0]  open_mask;
  logic [AW-1:0]  al_q;
  logic [CLW-1:0] cl_q;
  logic           bl8_q;
  logic [LW-1:0]  rl, wl;
  logic [2:0]     beats;
  logic           col_ok, wr_ok, fire, rd_live, wr_live, busy, cfg_legal;
  col_cmd_e       cmd_q;

  assign rl    = LW'(al_q) + LW'(cl_q);
  assign wl    = rl - LW'(1);
  assign beats = bl8_q ? 3'd4 : 3'd2;

  ddr2cc_bank_flags #(.NB(NB)) u_banks (
    .clk(clk), .rst_n(rst_n), .act(bank_act), .pre(bank_pre),
    .sel(bank_sel), .open_mask(open_mask)
  );

  ddr2cc_gap_timer #(.CW(3)) u_gap (
    .clk(clk), .rst_n(rst_n), .issue(fire), .issue_rd(!req_write),
    .bl8(bl8_q), .col_ok(col_ok), .wr_ok(wr_ok)
  );

  ddr2cc_data_window #(.DEPTH(DEPTH), .LW(LW)) u_rdwin (
    .clk(clk), .rst_n(rst_n), .start(fire && !req_write), .lat(rl),
    .beats(beats), .win(rd_win), .live(rd_live)
  );

  ddr2cc_data_window #(.DEPTH(DEPTH), .LW(LW)) u_wrwin (
    .clk(clk), .rst_n(rst_n), .start(fire && req_write), .lat(wl),
    .beats(beats), .win(wr_win), .live(wr_live)
  );

  assign req_ready = open_mask[req_bank] && col_ok && (!req_write || wr_ok);
  assign fire      = req_valid && req_ready;
  assign busy      = fire || rd_live || wr_live;
  assign cfg_legal = (cfg_al <= AW'(MAX_AL)) && (cfg_cl >= CLW'(MIN_CL)) &&
                     (cfg_cl <= CLW'(MAX_CL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      al_q  <= '0;
      cl_q  <= CLW'(MIN_CL);
      bl8_q <= 1'b0;
    end else if (cfg_load && !busy && cfg_legal) begin
      al_q  <= cfg_al;
      cl_q  <= cfg_cl;
      bl8_q <= cfg_bl8;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= CMD_NOP;
      cmd_bank <= '0;
    end else begin
      cmd_q <= fire ? (req_write ? CMD_WR : CMD_RD) : CMD_NOP;
      if (fire) cmd_bank <= req_bank;
    end
  end

  assign cmd_op = cmd_q;
endmodule

// File: rtl/ddr2cc_checker.sv
module ddr2cc_checker #(
  parameter int NB = 8,
  localparam int BW = $clog2(NB)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic [BW-1:0] req_bank,
  input logic [1:0]    cmd_op,
  input logic [BW-1:0] cmd_bank,
  input logic [NB-1:0] open_mask,
  input logic          bl8
);
  logic [6:0] since_cmd, since_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_cmd <= 7'd127;
      since_rd  <= 7'd127;
    end else begin
      if (cmd_op != 2'd0)          since_cmd <= 7'd1;
      else if (since_cmd != 7'd127) since_cmd <= since_cmd + 7'd1;
      if (cmd_op == 2'd1)          since_rd <= 7'd1;
      else if (since_rd != 7'd127)  since_rd <= since_rd + 7'd1;
    end
  end

  AST_READY_BANK_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> open_mask[req_bank]); // R3
  AST_ISSUE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (cmd_op == ($past(req_write) ? 2'd2 : 2'd1))); // R2
  AST_BANK_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (cmd_bank == $past(req_bank))); // R2
  AST_IDLE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> (cmd_op == 2'd0)); // R9
  AST_COL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op != 2'd0) |-> (since_cmd >= (bl8 ? 7'd4 : 7'd2))); // R4
  AST_RD_TO_WR_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 2'd2) |-> (since_rd >= (bl8 ? 7'd6 : 7'd4))); // R5
endmodule

bind ddr2cc_sched ddr2cc_checker #(.NB(NB)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_bank(req_bank), .cmd_op(cmd_op),
  .cmd_bank(cmd_bank), .open_mask(open_mask), .bl8(bl8_q)
);

// File: tb/sim_ddr2cc_sched.sv
`timescale 1ns/1ps
module sim_ddr2cc_sched;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bank_act = 0, bank_pre = 0, cfg_load = 0, cfg_bl8 = 0;
  logic req_valid = 0, req_write = 0;
  logic [2:0] bank_sel = 0, cfg_al = 0, cfg_cl = 0, req_bank = 0, cmd_bank;
  logic req_ready, rd_win, wr_win;
  logic [1:0] cmd_op;

  always #5 clk = ~clk;

  ddr2cc_sched u0 (
    .clk(clk), .rst_n(rst_n), .bank_act(bank_act), .bank_pre(bank_pre),
    .bank_sel(bank_sel), .cfg_load(cfg_load), .cfg_al(cfg_al), .cfg_cl(cfg_cl),
    .cfg_bl8(cfg_bl8), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_bank(req_bank), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .rd_win(rd_win), .wr_win(wr_win)
  );

  int nchk = 0, nfail = 0;
  bit done = 0;

  // reference model
  bit  mopen [8];
  int  last_cmd = -100, last_rd = -100, m_al = 0, m_cl = 3, cyc = 0;
  int  exp_cmd = 0, exp_bank = 0;
  bit  m_bl8 = 0, fire_m = 0, idle_now;
  byte cmd_at [8192];

  function automatic int mlen(); return m_bl8 ? 4 : 2; endfunction
  function automatic int mrl();  return m_al + m_cl;   endfunction

  function automatic bit win_exp(int kind, int lat);
    for (int c = cyc - lat - mlen() + 1; c <= cyc - lat; c++)
      if (c >= 0 && cmd_at[c] == kind) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit ready_exp(int bk, bit wr);
    return mopen[bk] && (cyc + 1 - last_cmd >= mlen()) &&
           (!wr || cyc + 1 - last_rd >= mlen() + 2);
  endfunction

  function automatic bit idle_exp();
    if (fire_m) return 1'b0;
    for (int c = cyc - mrl() - mlen() + 1; c <= cyc; c++) begin
      if (c >= 0 && cmd_at[c] == 1) return 1'b0;
      if (c >= 0 && cmd_at[c] == 2 && cyc - c <= mrl() + mlen() - 2) return 1'b0;
    end
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      idle_now = idle_exp();
      if (fire_m) begin
        cmd_at[cyc + 1] = req_write ? 8'd2 : 8'd1;
        last_cmd = cyc + 1;
        if (!req_write) last_rd = cyc + 1;
        exp_cmd  = req_write ? 2 : 1;
        exp_bank = int'(req_bank);
      end else exp_cmd = 0;
      if (bank_act) mopen[bank_sel] = 1'b1;
      if (bank_pre) mopen[bank_sel] = 1'b0;
      if (cfg_load && idle_now && cfg_al <= 5 && cfg_cl >= 3 && cfg_cl <= 6) begin
        m_al = int'(cfg_al); m_cl = int'(cfg_cl); m_bl8 = cfg_bl8;
      end
      if (cyc < 8190) cyc++;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s cycle %0d actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  task automatic step(bit a, bit p, int sel, bit v, bit wr, int bk,
                      bit ld, int al, int cl, bit b8);
    @(negedge clk);
    chk(int'(cmd_op) == exp_cmd, "R2/R9 cmd_op", int'(cmd_op), exp_cmd);
    if (exp_cmd != 0) chk(int'(cmd_bank) == exp_bank, "R2 cmd_bank", int'(cmd_bank), exp_bank);
    chk(rd_win == win_exp(1, mrl()), "R6/R8 rd_win", rd_win, win_exp(1, mrl()));
    chk(wr_win == win_exp(2, mrl() - 1), "R7/R8 wr_win", wr_win, win_exp(2, mrl() - 1));
    bank_act = a; bank_pre = p; bank_sel = 3'(sel);
    req_valid = v; req_write = wr; req_bank = 3'(bk);
    cfg_load = ld; cfg_al = 3'(al); cfg_cl = 3'(cl); cfg_bl8 = b8;
    #1;
    chk(req_ready == ready_exp(bk, wr), "R3/R4/R5 req_ready", req_ready, ready_exp(bk, wr));
    fire_m = v && ready_exp(bk, wr);
  endtask

  // holds a request until it is accepted
  task automatic send(bit wr, int bk);
    do step(0, 0, 0, 1, wr, bk, 0, 0, 0, 0); while (!fire_m);
  endtask

  task automatic quiet(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(150000 * 10);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    bit hv = 0, hw = 0; int hb = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(cmd_op == 2'd0, "R1 cmd_op", int'(cmd_op), 0);
    chk(!rd_win && !wr_win, "R1 windows", int'({rd_win, wr_win}), 0);
    for (int b = 0; b < 8; b++) begin
      req_bank = 3'(b); #1;
      chk(!req_ready, "R1 bank closed", req_ready, 0);
    end
    // R3: closed bank holds, then act/pre precedence
    step(0, 0, 0, 1, 0, 2, 0, 0, 0, 0);
    step(1, 1, 2, 1, 0, 2, 0, 0, 0, 0);   // both strobes: stays closed
    step(1, 0, 2, 0, 0, 2, 0, 0, 0, 0);
    // R4 seamless reads at default RL=3 BL4, then R5 turnaround
    send(0, 2); send(0, 2); send(0, 2); send(1, 2); send(0, 2);
    // R8 load while busy is ignored, then at idle it takes effect
    step(0, 0, 0, 0, 0, 0, 1, 2, 3, 0);
    quiet(12);
    step(0, 0, 0, 0, 0, 0, 1, 2, 3, 0);   // AL=2 CL=3 -> RL=5
    step(1, 0, 5, 0, 0, 0, 0, 0, 0, 0);
    send(0, 2); send(0, 5); send(1, 5); send(1, 2);
    quiet(14);
    step(0, 0, 0, 0, 0, 0, 1, 6, 3, 1);   // AL out of range: ignored
    step(0, 0, 0, 0, 0, 0, 1, 1, 4, 1);   // BL8, RL=5
    send(0, 2); send(0, 5); send(1, 5); send(0, 2);
    quiet(14);
    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      bit a, p, ld, b8; int sel, al, cl;
      a   = ($urandom % 6) == 0;
      p   = ($urandom % 14) == 0;
      sel = ($urandom % 2) ? int'($urandom % 3) : int'($urandom % 8);
      ld  = ($urandom % 30) == 0;
      al  = int'($urandom % 7);
      cl  = 2 + int'($urandom % 6);
      b8  = $urandom % 2;
      if (!(hv && !fire_m)) begin
        hv = ($urandom % 4) != 0;
        hw = ($urandom % 3) == 0;
        hb = ($urandom % 3 != 0) ? int'($urandom % 3) : int'($urandom % 8);
      end
      step(a, p, sel, hv, hw, hb, ld, al, cl, b8);
    end
    quiet(2);
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule